// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands into a 2W-bit product over W clock cycles, forming one partial product per cycle. It uses a single 2W-bit product register. The multiplier operand is placed in the low half of that register. Each cycle, the multiplicand is added into the high half when the current low bit is set, and the whole register then moves one place right. Both steps happen in the same clock.

The finished product comes out split in two. The upper half is on `hi` and the lower half is on `lo`. Both stay on the outputs until the next operation finishes.

A one-cycle `start` while the block is idle captures both operands and the mode. `busy` then covers the whole operation, and `done` pulses once when the new result appears. The signed mode works on magnitudes: it takes the absolute value of each operand, runs the same unsigned loop, and two's-complements the 2W-bit product at the end when exactly one operand was negative.

Top module: `shiftadd_multiplier`

## Requirements
- R1: After reset, and until the first operation ends, `busy` and `done` are 0, and `hi` and `lo` are all zeros.
- R2: A `start` sampled high while `busy` is 0 captures `op_a`, `op_b` and `signed_mode`. `busy` is 1 from the following cycle until the cycle in which `done` is 1.
- R3: `done` is 1 for exactly one cycle. That cycle follows the clock edge that is W+1 edges after the edge that accepted `start`. `busy` is 0 whenever `done` is 1.
- R4: With `signed_mode` = 0, the result is the full unsigned 2W-bit product. No carry is lost, so all-ones times all-ones gives 2^(2W) - 2^(W+1) + 1.
- R5: With `signed_mode` = 1, both operands are read as two's complement. The result is their 2W-bit two's-complement product, including when an operand is the most negative value and when the product is zero with the operand signs differing.
- R6: `hi` carries product bits 2W-1..W and `lo` carries bits W-1..0.
- R7: While `busy` is 1, changes on `start`, `op_a`, `op_b` and `signed_mode` have no effect. The running operation's result and its timing are unchanged.
- R8: `hi` and `lo` change only in the cycle where `done` is 1. They hold the previous result while a new operation runs.
- R9: The product register is loaded with zeros in its upper half and the multiplier in its lower half. Each cycle adds the multiplicand to the upper half only when bit 0 is 1, then shifts right by one. In a 4-bit build, 0010 times 0011 gives 0000 0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| signed_mode | input | 1 | 1: two's-complement operands; 0: unsigned operands |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when a new result is on `hi`/`lo` |
| hi | output | W | Upper half of the product |
| lo | output | W | Lower half of the product |

## Verification
The bench builds two copies of the block, one with W = 32 and one with W = 4. The 32-bit copy runs a vector table of carry-heavy and most-negative corner cases, a pseudo-random sweep in both modes, and directed checks of the handshake and of inputs changing while busy. The 4-bit copy makes an exhaustive check practical: every operand pair is run in both modes, and the textbook 0010 times 0011 case is checked as well.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_STEP = 2'd1,
    SEQ_FIX  = 2'd2
  } smul_seq_e;
endpackage

// File: rtl/smul_operand_prep.sv
module smul_operand_prep #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         flip_sign
);
  // Unsigned magnitude; the most negative value maps to 2^(W-1), which fits.
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic as_signed);
    if (as_signed && v[W-1]) return (~v) + W'(1);
    return v;
  endfunction

  always_comb begin
    a_mag     = magnitude(a_in, signed_mode);
    b_mag     = magnitude(b_in, signed_mode);
    flip_sign = signed_mode & (a_in[W-1] ^ b_in[W-1]);
  end
endmodule

// File: rtl/smul_step_datapath.sv
module smul_step_datapath #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  mcand_in,
  input  logic [W-1:0]  mplier_in,
  output logic [PW-1:0] prod
);
  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic [W:0]    partial_sum;
  logic [PW-1:0] prod_next;
  logic          add_taken;

  // One iteration: conditional add into the upper half with its carry kept,
  // then a right shift of the whole register.
  function automatic logic [W:0] add_upper(input logic [W-1:0] upper,
                                           input logic [W-1:0] addend,
                                           input logic         en);
    return {1'b0, upper} + {1'b0, (en ? addend : '0)};
  endfunction

  always_comb begin
    add_taken   = prod_q[0];
    partial_sum = add_upper(prod_q[PW-1:W], mcand_q, add_taken);
    prod_next   = {partial_sum, prod_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      prod_q  <= {{W{1'b0}}, mplier_in};
    end else if (step) begin
      prod_q  <= prod_next;
    end
  end

  assign prod = prod_q;

  assert_load_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prod_q[PW-1:W] == '0) && (prod_q[W-1:0] == $past(mplier_in)));

  assert_skip_add_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !prod_q[0]) |=> (prod_q == ($past(prod_q) >> 1)));

  assert_mcand_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mcand_q));
endmodule

// File: rtl/smul_sequencer.sv
module smul_sequencer
  import smul_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  smul_seq_e      state_q, state_d;
  logic [CW-1:0]  iter_q;
  logic           last_iter;
  logic           done_q;

  always_comb begin
    load      = start && (state_q == SEQ_IDLE);
    step      = (state_q == SEQ_STEP);
    finish    = (state_q == SEQ_FIX);
    busy      = (state_q != SEQ_IDLE);
    last_iter = (iter_q == CW'(W - 1));
    state_d   = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start) state_d = SEQ_STEP;
      SEQ_STEP: if (last_iter) state_d = SEQ_FIX;
      SEQ_FIX:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (load)      iter_q <= '0;
      else if (step) iter_q <= iter_q + CW'(1);
    end
  end

  assign done = done_q;

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (state_q != SEQ_IDLE) || done);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_fix_after_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> $past(step) && ($past(iter_q) == CW'(W - 1)));
endmodule

// File: rtl/shiftadd_multiplier.sv
module shiftadd_multiplier #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int PW = 2 * W;

  logic [W-1:0]  a_mag, b_mag;
  logic          flip_sign;
  logic          flip_q;
  logic          load, step, finish;
  logic [PW-1:0] prod;
  logic [PW-1:0] signed_prod;
  logic [W-1:0]  hi_q, lo_q;

  function automatic logic [PW-1:0] apply_sign(input logic [PW-1:0] p, input logic neg);
    if (neg) return (~p) + PW'(1);
    return p;
  endfunction

  smul_operand_prep #(.W(W)) u_prep (
    .signed_mode (signed_mode),
    .a_in        (op_a),
    .b_in        (op_b),
    .a_mag       (a_mag),
    .b_mag       (b_mag),
    .flip_sign   (flip_sign)
  );

  smul_sequencer #(.W(W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  smul_step_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (a_mag),
    .mplier_in (b_mag),
    .prod      (prod)
  );

  assign signed_prod = apply_sign(prod, flip_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (load) flip_q <= flip_sign;
      if (finish) begin
        hi_q <= signed_prod[PW-1:W];
        lo_q <= signed_prod[W-1:0];
      end
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({hi_q, lo_q}));

  assert_unsigned_no_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !signed_mode) |=> !flip_q);
endmodule

// File: tb/test_shiftadd_multiplier.sv
`timescale 1ns/1ps
module test_shiftadd_multiplier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // 32-bit instance
  logic        s_start = 0, s_mode = 0;
  logic [31:0] s_a = 0, s_b = 0;
  logic        busy32, done32;
  logic [31:0] hi32, lo32;

  shiftadd_multiplier #(.W(32)) i_shiftadd_multiplier (
    .clk(clk), .rst_n(rst_n), .start(s_start), .signed_mode(s_mode),
    .op_a(s_a), .op_b(s_b), .busy(busy32), .done(done32), .hi(hi32), .lo(lo32));

  // 4-bit instance
  logic       t_start = 0, t_mode = 0;
  logic [3:0] t_a = 0, t_b = 0;
  logic       busy4, done4;
  logic [3:0] hi4, lo4;

  shiftadd_multiplier #(.W(4)) i_shiftadd_multiplier_w4 (
    .clk(clk), .rst_n(rst_n), .start(t_start), .signed_mode(t_mode),
    .op_a(t_a), .op_b(t_b), .busy(busy4), .done(done4), .hi(hi4), .lo(lo4));

  // {mode, a, b, expected}
  localparam int NV = 12;
  localparam logic [128:0] VEC [NV] = '{
    {1'b0, 32'h00000002, 32'h00000003, 64'h0000000000000006},
    {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFE00000001},
    {1'b0, 32'h00000000, 32'h12345678, 64'h0000000000000000},
    {1'b0, 32'h80000000, 32'h00000002, 64'h0000000100000000},
    {1'b0, 32'h00010000, 32'h00010000, 64'h0000000100000000},
    {1'b0, 32'h12345678, 32'h00000001, 64'h0000000012345678},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0000000000000001},
    {1'b1, 32'h80000000, 32'h80000000, 64'h4000000000000000},
    {1'b1, 32'h80000000, 32'h00000001, 64'hFFFFFFFF80000000},
    {1'b1, 32'hFFFFFFFE, 32'h00000003, 64'hFFFFFFFFFFFFFFFA},
    {1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'h3FFFFFFF00000001},
    {1'b1, 32'h00000000, 32'h80000000, 64'h0000000000000000}
  };

  function automatic logic [63:0] ref32(input logic [31:0] a, input logic [31:0] b, input logic m);
    logic [63:0] ua, ub;
    logic signed [63:0] sa, sb;
    ua = {32'b0, a}; ub = {32'b0, b};
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    if (m) return 64'(sa * sb);
    return ua * ub;
  endfunction

  function automatic logic [7:0] ref4(input int a, input int b, input bit m);
    int x, y, p;
    x = (m && a >= 8) ? a - 16 : a;
    y = (m && b >= 8) ? b - 16 : b;
    p = x * y;
    return p[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op32(input logic [31:0] a, input logic [31:0] b, input logic m,
                      output logic [63:0] res, output int lat);
    @(negedge clk);
    s_a = a; s_b = b; s_mode = m; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    lat = 0;
    while (!done32 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = {hi32, lo32};
  endtask

  task automatic op4(input logic [3:0] a, input logic [3:0] b, input logic m,
                     output logic [7:0] res, output int lat);
    @(negedge clk);
    t_a = a; t_b = b; t_mode = m; t_start = 1'b1;
    @(negedge clk);
    t_start = 1'b0;
    lat = 0;
    while (!done4 && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    res = {hi4, lo4};
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] res, prev;
    logic [7:0]  r4;
    int lat;
    logic [31:0] lfsr;
    bit held_ok;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy32 && !done32, "R1 busy/done at reset", {62'b0, busy32, done32}, 64'h0);
    chk({hi32, lo32} == 64'h0, "R1 hi/lo at reset", {hi32, lo32}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy32 && !done32 && {hi32, lo32} == 64'h0, "R1 idle after reset release",
        {hi32, lo32}, 64'h0);

    // Vector table: R4, R5, R6
    foreach (VEC[i]) begin
      op32(VEC[i][127:96], VEC[i][95:64], VEC[i][128], res, lat);
      chk(res == VEC[i][63:0], VEC[i][128] ? "R5 signed vector" : "R4 unsigned vector",
          res, VEC[i][63:0]);
      chk(lat == 33, "R3 latency W+1", 64'(lat), 64'd33);
    end

    // R6: halves placed correctly
    op32(32'hFFFFFFFF, 32'h00000002, 1'b0, res, lat);
    chk(hi32 == 32'h00000001 && lo32 == 32'hFFFFFFFE, "R6 hi/lo split",
        {hi32, lo32}, 64'h00000001FFFFFFFE);

    // R3: done lasts one cycle, busy low with done
    chk(!busy32, "R3 busy low with done", {63'b0, busy32}, 64'h0);
    @(negedge clk);
    chk(!done32, "R3 done single pulse", {63'b0, done32}, 64'h0);

    // Pseudo-random sweep in both modes: R4, R5
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] ra, rb;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      ra = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      rb = lfsr;
      op32(ra, rb, k[0], res, lat);
      chk(res == ref32(ra, rb, k[0]), k[0] ? "R5 random signed" : "R4 random unsigned",
          res, ref32(ra, rb, k[0]));
    end

    // R2, R7, R8: inputs while busy are ignored; results held during run
    op32(32'h00000010, 32'h00000020, 1'b0, prev, lat);
    @(negedge clk);
    s_a = 32'h00000005; s_b = 32'h00000007; s_mode = 1'b0; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    chk(busy32, "R2 busy after start", {63'b0, busy32}, 64'h1);
    held_ok = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if ({hi32, lo32} != prev) held_ok = 1'b0;
    end
    s_a = 32'hFFFFFFFF; s_b = 32'h80000000; s_mode = 1'b1; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    lat = 5;
    while (!done32 && lat < 200) begin
      @(negedge clk);
      if (!done32 && {hi32, lo32} != prev) held_ok = 1'b0;
      if (!done32 && !busy32) held_ok = 1'b0;
      lat++;
    end
    chk(held_ok, "R8 result held and busy kept while running", {hi32, lo32}, prev);
    chk({hi32, lo32} == 64'd35, "R7 start/operands ignored while busy", {hi32, lo32}, 64'd35);
    chk(lat == 33, "R7 timing unchanged by busy start", 64'(lat), 64'd33);
    repeat (5) @(negedge clk);
    chk({hi32, lo32} == 64'd35 && !busy32, "R8 result held while idle", {hi32, lo32}, 64'd35);

    // R9: 4-bit textbook case
    op4(4'b0010, 4'b0011, 1'b0, r4, lat);
    chk(r4 == 8'b0000_0110, "R9 4-bit 0010 x 0011", 64'(r4), 64'h06);
    chk(lat == 5, "R3 4-bit latency W+1", 64'(lat), 64'd5);

    // Exhaustive 4-bit: R4, R5
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          op4(4'(a), 4'(b), m[0], r4, lat);
          chk(r4 == ref4(a, b, m[0]), m[0] ? "R5 4-bit exhaustive signed" : "R4 4-bit exhaustive unsigned",
              64'(r4), 64'(ref4(a, b, m[0])));
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule